// File: doc/BRIEF.md
# Dual-Law Companded PCM Expander

This block turns one 8-bit companded telephony code into a linear two's-complement sample. Each accepted input carries its own law select, so a stream may mix A-law and µ-law codes from one sample to the next with no reset or setup in between. An A-law code gives a 13-bit result and a µ-law code gives a 14-bit result. Both appear on one 14-bit output bus, with the A-law value sign-extended.

A sample is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result is registered and appears on the next edge, with `out_valid` high for that single cycle. The block never applies backpressure once it is out of reset. The output register holds its last value until the next accepted sample.

Top module: `pcm_expander`

## Requirements
- R1: While reset is asserted, `in_ready` and `out_valid` are 0 and `out_sample` is 0.
- R2: Within four clock cycles after reset is released, `in_ready` rises, and it then stays high.
- R3: An accepted input (`in_valid` and `in_ready` high at a rising edge) makes `out_valid` high in the following cycle only. With no accepted input, `out_valid` is 0.
- R4: When `in_valid` is low, the input is ignored. `out_sample` keeps the last decoded value and `out_valid` stays 0.
- R5: With `in_law`=0 (A-law), the code is first XORed with 0x55. Bit 7 is then the sign, with 1 meaning positive. Bits 6:4 give segment s and bits 3:0 give mantissa m. The magnitude is 2m+1 when s=0, and (2m+33)<<(s-1) otherwise.
- R6: An A-law result spans 13 bits and is sign-extended, so `out_sample[13]` equals `out_sample[12]`. Code 0xAA gives +4032 and code 0x2A gives -4032.
- R7: With `in_law`=1 (µ-law), all code bits are inverted first. Bit 7 is then the sign, with 1 meaning negative. Bits 6:4 give s and bits 3:0 give m. The magnitude is ((2m+33)<<s)-33. Code 0x80 gives +8031 and code 0x00 gives -8031.
- R8: The law may differ between back-to-back accepted samples, and each sample is decoded under its own `in_law`.
- R9: The µ-law codes 0xFF and 0x7F both decode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input code strobe |
| in_ready | output | 1 | High when the block accepts codes |
| in_code | input | 8 | Companded PCM code |
| in_law | input | 1 | 0 = A-law, 1 = µ-law, sampled with the code |
| out_valid | output | 1 | One-cycle flag for a new result |
| out_sample | output | 14 | Linear two's-complement sample |

## Verification
The assertions assume that `in_code` and `in_law` are known values whenever `in_valid` is high. They also assume that `rst_n` changes only away from the rising clock edge. The stimulus follows both rules: it drives every input on the falling edge and holds `in_valid` low except while a defined code is presented. It sends every one of the 256 codes under each law, some back to back with alternating laws and some with idle gaps, so that the hold and one-cycle-flag rules are exercised alongside the decode.

// File: rtl/pcm_exp_pkg.sv
package pcm_exp_pkg;
  localparam int CODE_W   = 8;
  localparam int SEG_W    = 3;
  localparam int MANT_W   = 4;
  localparam int BASE_W   = MANT_W + 2;
  localparam int A_MAG_W  = 12;
  localparam int A_OUT_W  = A_MAG_W + 1;
  localparam int MU_MAG_W = 13;
  localparam int MU_OUT_W = MU_MAG_W + 1;
  localparam int MU_BIAS  = 33;
  localparam logic [CODE_W-1:0] A_EVEN_MASK = 8'h55;

  typedef enum logic {
    LAW_A  = 1'b0,
    LAW_MU = 1'b1
  } law_e;

  typedef struct packed {
    logic               sign;
    logic [SEG_W-1:0]   seg;
    logic [MANT_W-1:0]  mant;
  } code_fields_t;
endpackage

// File: rtl/pcm_rst_sync.sv
module pcm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pcm_alaw_core.sv
module pcm_alaw_core
  import pcm_exp_pkg::*;
(
  input  logic [CODE_W-1:0]  code,
  output logic [A_OUT_W-1:0] sample
);
  code_fields_t            f;
  logic [BASE_W-1:0]       base;
  logic [A_MAG_W-1:0]      mag;
  logic [A_MAG_W-1:0]      shifted;

  always_comb begin
    f       = code_fields_t'(code ^ A_EVEN_MASK);
    // leading one only above the first segment
    base    = {(f.seg != '0), f.mant, 1'b1};
    shifted = A_MAG_W'(base) << (f.seg - SEG_W'(1));
    mag     = (f.seg == '0) ? A_MAG_W'(base) : shifted;
    sample  = f.sign ? {1'b0, mag} : (A_OUT_W'(0) - {1'b0, mag});
  end
endmodule

// File: rtl/pcm_ulaw_core.sv
module pcm_ulaw_core
  import pcm_exp_pkg::*;
(
  input  logic [CODE_W-1:0]   code,
  output logic [MU_OUT_W-1:0] sample
);
  code_fields_t            f;
  logic [BASE_W-1:0]       base;
  logic [MU_MAG_W-1:0]     biased;
  logic [MU_MAG_W-1:0]     mag;

  always_comb begin
    f      = code_fields_t'(~code);
    base   = {1'b1, f.mant, 1'b1};
    biased = MU_MAG_W'(base) << f.seg;
    mag    = biased - MU_MAG_W'(MU_BIAS);
    sample = f.sign ? (MU_OUT_W'(0) - {1'b0, mag}) : {1'b0, mag};
  end
endmodule

// File: rtl/pcm_expander.sv
module pcm_expander
  import pcm_exp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CODE_W-1:0]    in_code,
  input  logic                 in_law,
  output logic                 out_valid,
  output logic [MU_OUT_W-1:0]  out_sample
);
  logic                  rst_sync_n;
  logic                  ready_q, ready_d;
  logic                  valid_q, valid_d;
  logic [MU_OUT_W-1:0]   sample_q, sample_d;
  logic                  accept;
  logic [A_OUT_W-1:0]    a_sample;
  logic [MU_OUT_W-1:0]   mu_sample;
  law_e                  law;

  pcm_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pcm_alaw_core alaw_i (.code(in_code), .sample(a_sample));
  pcm_ulaw_core ulaw_i (.code(in_code), .sample(mu_sample));

  always_comb begin
    law      = law_e'(in_law);
    accept   = in_valid && ready_q;
    ready_d  = 1'b1;
    valid_d  = accept;
    sample_d = sample_q;
    if (accept) begin
      if (law == LAW_MU) sample_d = mu_sample;
      else               sample_d = {a_sample[A_OUT_W-1], a_sample};
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ready_q  <= 1'b0;
      valid_q  <= 1'b0;
      sample_q <= '0;
    end else begin
      ready_q <= ready_d;
      valid_q <= valid_d;
      if (accept) sample_q <= sample_d;
    end
  end

  assign in_ready   = ready_q;
  assign out_valid  = valid_q;
  assign out_sample = sample_q;

  assert_ready_sticks_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_ready |=> in_ready);
  assert_flag_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready) |=> out_valid);
  assert_no_flag_idle_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(in_valid && in_ready) |=> !out_valid);
  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(in_valid && in_ready) |=> $stable(out_sample));
  assert_a_sign_extend_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready && !in_law) |=> (out_sample[13] == out_sample[12]));
  assert_mu_zero_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready && in_law && (in_code[6:0] == 7'h7F)) |=> (out_sample == '0));
endmodule

// File: tb/pcm_expander_tb_top.sv
`timescale 1ns/1ps
module pcm_expander_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_code;
  logic        in_law;
  logic        out_valid;
  logic [13:0] out_sample;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int exp_q[$];
  string tag_q[$];
  int last_val = 0;

  always #4 clk = ~clk;

  pcm_expander dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_law(in_law), .out_valid(out_valid), .out_sample(out_sample)
  );

  // R5 reference
  function automatic int ref_a(input logic [7:0] c);
    logic [7:0] x;
    int s, m, mag;
    x = c ^ 8'h55;
    s = int'(x[6:4]);
    m = int'(x[3:0]);
    mag = (s == 0) ? (2*m + 1) : ((2*m + 33) << (s - 1));
    return x[7] ? mag : -mag;
  endfunction

  // R7 reference
  function automatic int ref_mu(input logic [7:0] c);
    logic [7:0] u;
    int s, m, mag;
    u = ~c;
    s = int'(u[6:4]);
    m = int'(u[3:0]);
    mag = ((2*m + 33) << s) - 33;
    return u[7] ? -mag : mag;
  endfunction

  function automatic int as_int(input logic [13:0] v);
    return int'(signed'(v));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic send(input logic [7:0] c, input logic law, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = c;
    in_law   = law;
    exp_q.push_back(law ? ref_mu(c) : ref_a(c));
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_code  = 8'hxx;
      in_law   = 1'bx;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && in_ready) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected flag", 1, 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(as_int(out_sample) == e, t, as_int(out_sample), e);
          last_val = as_int(out_sample);
        end
      end else if (!in_valid) begin
        check(as_int(out_sample) == last_val, "R4 hold", as_int(out_sample), last_val);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int waited;
    rst_n = 1'b0; in_valid = 1'b0; in_code = 8'h00; in_law = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    check(in_ready == 1'b0, "R1 ready", int'(in_ready), 0);
    check(out_sample == '0, "R1 sample", as_int(out_sample), 0);
    rst_n = 1'b1;
    waited = 0;
    while (!in_ready && waited < 6) begin
      @(negedge clk);
      waited++;
    end
    check(waited <= 4, "R2 ready rise", waited, 4);

    // R6 / R7 extremes
    send(8'hAA, 1'b0, "R6 A max");
    send(8'h2A, 1'b0, "R6 A min");
    send(8'h80, 1'b1, "R7 mu max");
    send(8'h00, 1'b1, "R7 mu min");
    // R9 zeros
    send(8'hFF, 1'b1, "R9 mu +0");
    send(8'h7F, 1'b1, "R9 mu -0");
    idle(3);

    // R5 full sweep, back to back
    for (int c = 0; c < 256; c++) send(8'(c), 1'b0, "R5 A sweep");
    idle(2);
    // R7 full sweep with gaps
    for (int c = 0; c < 256; c++) begin
      send(8'(c), 1'b1, "R7 mu sweep");
      if (c % 7 == 3) idle(2);
    end
    idle(2);
    // R8 alternating law every sample
    for (int c = 0; c < 256; c++) send(8'(c * 37 + 11), 1'(c % 2), "R8 law switch");
    idle(4);
    // R4 invalid codes ignored
    in_code = 8'h00; in_law = 1'b1;
    repeat (3) @(negedge clk);
    idle(2);
    check(out_valid == 1'b0, "R3 idle flag", int'(out_valid), 0);
    check(exp_q.size() == 0, "R3 all drained", exp_q.size(), 0);
    check(in_ready == 1'b1, "R2 ready stays", int'(in_ready), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule